// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `W` bits each over several clock cycles and returns the full `2W`-bit product. It walks the multiplier from its least significant bit upward, one bit per cycle. In each cycle it compares that bit with the bit below it, and the bit below the lowest bit counts as 0. A change in value triggers an addition or a subtraction of the multiplicand into a partial-product register. No change means the adder result is not used. The partial-product and multiplier registers then shift right by one bit, and the shift keeps the sign.

Operands arrive through a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a multiplication is running, `in_ready` is low. An upstream source holding `in_valid` high in that window is back-pressured: its operands are not taken, and they do not affect the running multiplication. When the block finishes it raises `done` for one cycle. The product and a count of the add or subtract steps that were performed then stay stable until the next request is taken. The count shows how much adder work the recoding saved for a given multiplier.

Top module: `booth_mul_seq`

## Requirements
- R1: After `done`, `product` equals the signed product of `mcand` and `mplier` as a `2W`-bit two's-complement value.
- R2: In each step, the current multiplier bit is paired with the bit to its right, and the bit right of bit 0 is taken as 0. Pair (current=1, right=0) subtracts the multiplicand. Pair (0,1) adds it. Pairs (0,0) and (1,1) leave the partial product unchanged before the arithmetic right shift.
- R3: `op_count` equals the number of bit positions i in 0..W-1 where `mplier[i]` differs from the bit to its right (0 for i=0). For W=8, 0x55 gives 8, 0xAA gives 7 and 0x00 gives 0. The count restarts at 0 when a request is taken.
- R4: A run of ones costs two operations, one at its low end and one above its high end. For W=8, multiplier 0x7F gives `op_count` 2, and 0xFF (a run ending at the sign bit) gives 1.
- R5: `busy` goes high on the edge that takes a request and stays high for exactly W cycles. `done` is high for exactly the one cycle after `busy` falls.
- R6: `in_ready` is the inverse of `busy`. A request offered while `busy` is high is not taken and does not alter the result of the running multiplication.
- R7: `product` and `op_count` hold their values from `done` until the next request is taken.
- R8: The most negative operand times itself gives the correct result. For W=8, 0x80 x 0x80 = 0x4000 with `op_count` 1.
- R9: After reset, `busy` and `done` are 0, `in_ready` is 1, and `product` and `op_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take operands (idle) |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product, valid from `done` |
| op_count | output | $clog2(W+1) | Add/subtract steps used by the last multiplication |

## Verification
The bench builds the block with W=8. That width is small enough to sweep every 8-bit multiplier against a set of edge multiplicands: zero, one, both extremes and a mixed pattern. The sweep reaches the alternating worst case, long runs of ones, the sign-bit run and the most-negative-squared corner. A behavioural model tracks `busy`, `done`, `in_ready`, `product` and `op_count` on every clock. That model also covers a request held high across a whole busy window.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // Recode one multiplier bit and its right neighbour into an adder action.
  function automatic booth_op_e pair_to_op(input logic cur, input logic right);
    case ({cur, right})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      right_bit,
  output booth_op_e op,
  output logic      active
);
  assign op     = pair_to_op(cur_bit, right_bit);
  assign active = (op != OP_NONE);
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  input  booth_op_e      op,
  output logic           cur_bit,
  output logic           right_bit,
  output logic [2*W-1:0] product
);
  localparam int AW = W + 1;  // one guard bit keeps -(most negative) in range

  logic [AW-1:0] acc;
  logic [W-1:0]  mq;
  logic          q_right;
  logic [W-1:0]  mc;
  logic [AW-1:0] mc_ext;
  logic [AW-1:0] sum;

  assign mc_ext = {mc[W-1], mc};

  always_comb begin
    case (op)
      OP_ADD:  sum = acc + mc_ext;
      OP_SUB:  sum = acc - mc_ext;
      default: sum = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      mq      <= '0;
      q_right <= 1'b0;
      mc      <= '0;
    end else if (load) begin
      acc     <= '0;
      mq      <= mplier_in;
      q_right <= 1'b0;
      mc      <= mcand_in;
    end else if (step) begin
      acc     <= {sum[AW-1], sum[AW-1:1]};
      mq      <= {sum[0], mq[W-1:1]};
      q_right <= mq[0];
    end
  end

  assign cur_bit   = mq[0];
  assign right_bit = q_right;
  assign product   = {acc[W-1:0], mq};

  // R2
  skip_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (mq[0] == q_right)) |=>
      (acc == {$past(acc[AW-1]), $past(acc[AW-1:1])}));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(acc) && $stable(mq)));

  // R6
  mcand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(mc));
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   step_active,
  output logic                   busy,
  output logic                   done,
  output logic [$clog2(W+1)-1:0] ops
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = $clog2(W + 1);

  logic [IW-1:0] iter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      iter <= '0;
      ops  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        iter <= '0;
        ops  <= '0;
      end else if (busy) begin
        iter <= iter + 1'b1;
        if (step_active) ops <= ops + CW'(1);
        if (iter == IW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  ops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !(busy && step_active)) |=> $stable(ops));

  // R3
  ops_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ops == '0));

  // R6
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [W-1:0]           mcand,
  input  logic [W-1:0]           mplier,
  output logic                   busy,
  output logic                   done,
  output logic [2*W-1:0]         product,
  output logic [$clog2(W+1)-1:0] op_count
);
  logic      accept;
  logic      cur_bit, right_bit, step_active;
  booth_op_e op;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  booth_recode u_recode (
    .cur_bit   (cur_bit),
    .right_bit (right_bit),
    .op        (op),
    .active    (step_active)
  );

  booth_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (busy),
    .mcand_in  (mcand),
    .mplier_in (mplier),
    .op        (op),
    .cur_bit   (cur_bit),
    .right_bit (right_bit),
    .product   (product)
  );

  booth_seq_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .step_active (step_active),
    .busy        (busy),
    .done        (done),
    .ops         (op_count)
  );

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> ($stable(product) && $stable(op_count)));
endmodule

// File: tb/sim_booth_mul_seq.sv
`timescale 1ns/1ps
module sim_booth_mul_seq;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, busy, done;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic [2*W-1:0] product;
  logic [CW-1:0] op_count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  booth_mul_seq #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand(mcand), .mplier(mplier), .busy(busy), .done(done),
    .product(product), .op_count(op_count)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return (2*W)'(pa * pb);
  endfunction

  function automatic int ref_ops(input logic [W-1:0] b);
    int n = 0;
    for (int i = 0; i < W; i++) begin
      logic right = (i == 0) ? 1'b0 : b[i-1];
      if (b[i] != right) n++;
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int             m_cnt = 0;
  bit             m_done = 0;
  bit             m_have = 1;
  logic [2*W-1:0] m_prod = '0, m_next_prod = '0;
  int             m_ops = 0, m_next_ops = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_done <= 0; m_have <= 1; m_prod <= '0; m_ops <= 0;
    end else begin
      m_done <= 0;
      if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_done <= 1; m_have <= 1; m_prod <= m_next_prod; m_ops <= m_next_ops;
        end
      end else if (in_valid) begin
        m_cnt <= W;
        m_have <= 0;
        m_next_prod <= ref_prod(mcand, mplier);
        m_next_ops <= ref_ops(mplier);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (m_cnt > 0), "R5", "model busy", busy, m_cnt > 0);
      chk(done == m_done, "R5", "model done", done, m_done);
      chk(in_ready == !busy, "R6", "model in_ready", in_ready, !busy);
      if (m_have) begin
        chk(product == m_prod, "R7", "model product", product, m_prod);
        chk(int'(op_count) == m_ops, "R7", "model op_count", op_count, m_ops);
      end
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int waitc = 0;
    @(negedge clk);
    in_valid = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    in_valid = 1'b0;
    while (!done && waitc < W + 4) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(product == ref_prod(a, b), req, "product", product, ref_prod(a, b));
    chk(int'(op_count) == ref_ops(b), "R3", "op_count", op_count, ref_ops(b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] edge_a [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hC3};
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 0, "R9", "busy", busy, 0);
    chk(done == 0, "R9", "done", done, 0);
    chk(in_ready == 1, "R9", "in_ready", in_ready, 1);
    chk(product == 0, "R9", "product", product, 0);
    chk(op_count == 0, "R9", "op_count", op_count, 0);

    // R2 recoding: 0x01 is sub at bit0 then add at bit1; 0x00 does nothing
    run(8'd3, 8'h01, "R2");
    chk(op_count == 2, "R2", "ops 0x01", op_count, 2);
    run(8'd3, 8'h00, "R2");
    chk(product == 0 && op_count == 0, "R2", "ops 0x00", op_count, 0);
    // R3 alternating worst cases
    run(8'd5, 8'h55, "R3");
    chk(op_count == 8, "R3", "ops 0x55", op_count, 8);
    run(8'hF6, 8'hAA, "R3");
    chk(op_count == 7, "R3", "ops 0xAA", op_count, 7);
    // R4 runs of ones
    run(8'd9, 8'h7F, "R4");
    chk(op_count == 2, "R4", "ops 0x7F", op_count, 2);
    run(8'd9, 8'hFF, "R4");
    chk(op_count == 1, "R4", "ops 0xFF", op_count, 1);
    // R8 most negative squared
    run(8'h80, 8'h80, "R8");
    chk(product == 16'h4000, "R8", "0x80*0x80", product, 16'h4000);
    chk(op_count == 1, "R8", "ops 0x80", op_count, 1);
    run(8'h80, 8'h7F, "R8");
    chk(product == 16'hC080, "R8", "0x80*0x7F", product, 16'hC080);

    // R6 request held during busy is ignored
    @(negedge clk);
    in_valid = 1'b1; mcand = 8'd7; mplier = 8'hF3;
    @(negedge clk);
    mcand = 8'h11; mplier = 8'h22;
    repeat (W - 1) begin
      chk(in_ready == 0, "R6", "in_ready while busy", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1, "R5", "done after W cycles", done, 1);
    chk(product == ref_prod(8'd7, 8'hF3), "R6", "held request ignored",
        product, ref_prod(8'd7, 8'hF3));
    chk(op_count == ref_ops(8'hF3), "R6", "held request ops", op_count, ref_ops(8'hF3));
    // R7 hold
    held = product;
    repeat (5) @(negedge clk);
    chk(product == held, "R7", "product held", product, held);
    chk(done == 0, "R5", "done single pulse", done, 0);

    // R1 sweep of every multiplier against edge multiplicands
    foreach (edge_a[k])
      for (int b = 0; b < (1 << W); b++)
        run(edge_a[k], W'(b), "R1");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule